// File: doc/BRIEF.md
# Byte-Addressed Word Store with Single-Error Correction

This block holds a small array of 38-bit physical words. Each word carries four data bytes (byte addresses 4N to 4N+3) and six Hamming check bits. Callers see a plain byte port. A read fetches the whole physical word and repairs any single flipped bit. It then returns the addressed byte one cycle later. A byte write fetches the word, repairs it, replaces one byte lane, recomputes all six check bits and stores the complete 38-bit word back.

A read can stand alone or form part of a multi-beat read operation. The caller marks the first beat of each operation, and the following beats keep the operation going. A registered flag reports whether any word read during the current operation needed a repair. A later operation that needs no repair clears the flag, and so does reset.

A test-only port flips one chosen stored bit of one chosen word. This lets the correction path be exercised at the boundary of the block.

Top module: `byte_ecc_store`

## Requirements
- R1: A read request (`req_vld`=1, `req_wr`=0) returns the byte at `req_addr` on `rd_data`, with `rd_vld`=1, in the cycle after the request edge. The word index is `req_addr[ADDR_W-1:2]` and the byte lane is `req_addr[1:0]`, with lane 0 in bits 7:0. `rd_vld` is 0 in every cycle that does not follow a read request.
- R2: If exactly one of the 38 stored bits of a word has flipped, a read of any byte in that word still returns the written value.
- R3: A byte write replaces only the addressed lane. The other three bytes of the word keep their written values, even if one bit of the stored word had flipped, and all six check bits are recomputed. A following read of that word therefore needs no correction.
- R4: After a read beat with `req_first`=1, `corr_flag` is 1 exactly when that beat's word needed correction.
- R5: After a read beat with `req_first`=0, `corr_flag` is the OR of its previous value and the correction need of that beat.
- R6: Codeword index i holds Hamming position i+1, so the check bits sit at indices 0, 1, 3, 7, 15 and 31. A flipped check bit leaves the returned data unchanged and still sets `corr_flag`.
- R7: During and right after reset, `corr_flag` and `rd_vld` are 0, and every word holds all-zero data with valid check bits.
- R8: A write request, or a cycle with no request, leaves `corr_flag` unchanged.
- R9: `inj_en`=1 flips codeword index `inj_pos` of word `inj_word` at that clock edge. The injection is ignored when `inj_pos` is 38 or more, or when a write to the same word happens in the same cycle, in which case the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Access request valid |
| req_wr | input | 1 | 1 = byte write, 0 = byte read |
| req_first | input | 1 | Read beat opens a new read operation |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| inj_en | input | 1 | Test-only bit-flip strobe |
| inj_word | input | ADDR_W-2 | Word index for the flip |
| inj_pos | input | 6 | Codeword index to flip (0..37) |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte |
| corr_flag | output | 1 | Current read operation needed a correction |

## Verification
Some behaviours are checked by assertions on every cycle. These are the one-cycle relation between a read request and `rd_vld`, the stability of `corr_flag` across writes and idle cycles, the way the flag accumulates over continuation beats, the cleared outputs after reset, and identical data from two back-to-back reads of one address with no flip in between. The other behaviours can only be shown by the bench's scenarios. These are the repair of a flip at each of the 38 codeword indices, the check-bit cases, the write path that repairs and re-encodes neighbouring bytes, and the two cases where an injection is ignored.

// File: rtl/bes_pkg.sv
package bes_pkg;
   localparam int DATA_W = 32;
   localparam int CHK_W  = 6;
   localparam int CW_W   = DATA_W + CHK_W;
   localparam int LANES  = DATA_W / 8;

   typedef logic [CW_W-1:0]   cw_t;
   typedef logic [DATA_W-1:0] dw_t;
   typedef logic [CHK_W-1:0]  syn_t;

   // Hamming position p (1-based) is a check position when p is a power of two
   function automatic bit is_chk_pos(int p);
      return (p & (p - 1)) == 0;
   endfunction

   // 1-based codeword position of data bit k
   function automatic int data_pos(int k);
      int n;
      int r;
      n = 0;
      r = 0;
      for (int p = 1; p <= CW_W; p++) begin
         if (!is_chk_pos(p)) begin
            if (n == k) r = p;
            n++;
         end
      end
      return r;
   endfunction

   // codeword indices whose position has bit c set
   function automatic cw_t cov_mask(int c);
      cw_t m;
      m = '0;
      for (int p = 1; p <= CW_W; p++)
         if (((p >> c) & 1) == 1) m[p-1] = 1'b1;
      return m;
   endfunction

   // data bits covered by check bit c
   function automatic dw_t data_cov(int c);
      dw_t m;
      m = '0;
      for (int k = 0; k < DATA_W; k++)
         if (((data_pos(k) >> c) & 1) == 1) m[k] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/bes_encode.sv
module bes_encode
   import bes_pkg::*;
(
   input  dw_t data_i,
   output cw_t cw_o
);
   for (genvar k = 0; k < DATA_W; k++) begin : g_data
      assign cw_o[data_pos(k)-1] = data_i[k];
   end
   for (genvar c = 0; c < CHK_W; c++) begin : g_chk
      assign cw_o[(1 << c) - 1] = ^(data_i & data_cov(c));
   end
endmodule

// File: rtl/bes_decode.sv
module bes_decode
   import bes_pkg::*;
(
   input  cw_t  cw_i,
   output dw_t  data_o,
   output logic err_o
);
   syn_t syn;
   cw_t  flip;
   cw_t  fixed;

   for (genvar c = 0; c < CHK_W; c++) begin : g_syn
      assign syn[c] = ^(cw_i & cov_mask(c));
   end
   for (genvar i = 0; i < CW_W; i++) begin : g_flip
      assign flip[i] = (syn == CHK_W'(i + 1));
   end
   assign fixed = cw_i ^ flip;
   for (genvar k = 0; k < DATA_W; k++) begin : g_ext
      assign data_o[k] = fixed[data_pos(k)-1];
   end
   // any nonzero syndrome counts as a repair, including check-bit and out-of-range codes
   assign err_o = |syn;
endmodule

// File: rtl/bes_bank.sv
module bes_bank
   import bes_pkg::*;
#(
   parameter int WORDS = 16,
   localparam int WAW = $clog2(WORDS)
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [WAW-1:0] rd_idx,
   output cw_t            rd_cw,
   input  logic           wr_en,
   input  logic [WAW-1:0] wr_idx,
   input  cw_t            wr_cw,
   input  logic           inj_en,
   input  logic [WAW-1:0] inj_idx,
   input  logic [5:0]     inj_pos
);
   cw_t mem [WORDS];
   cw_t inj_vec;

   assign inj_vec = (inj_pos < 6'(CW_W)) ? (cw_t'(1) << inj_pos) : '0;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic hit_wr;
      logic hit_inj;
      assign hit_wr  = wr_en  && (wr_idx  == WAW'(w));
      assign hit_inj = inj_en && (inj_idx == WAW'(w));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       mem[w] <= '0;
         else if (hit_wr)  mem[w] <= wr_cw;
         else if (hit_inj) mem[w] <= mem[w] ^ inj_vec;
      end
   end

   assign rd_cw = mem[rd_idx];
endmodule

// File: rtl/byte_ecc_store.sv
module byte_ecc_store
   import bes_pkg::*;
#(
   parameter int ADDR_W = 6,
   localparam int WAW   = ADDR_W - 2,
   localparam int WORDS = 1 << WAW
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic              req_wr,
   input  logic              req_first,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_wdata,
   input  logic              inj_en,
   input  logic [WAW-1:0]    inj_word,
   input  logic [5:0]        inj_pos,
   output logic              rd_vld,
   output logic [7:0]        rd_data,
   output logic              corr_flag
);
   if (ADDR_W < 3 || ADDR_W > 12) begin : g_bad_addr_w
      $error("byte_ecc_store: ADDR_W must lie in 3..12");
   end

   logic [WAW-1:0] widx;
   logic [1:0]     lane;
   cw_t            stored_cw;
   cw_t            new_cw;
   dw_t            dec_data;
   dw_t            merged;
   logic           dec_err;
   logic           is_rd;
   logic           is_wr;
   logic [7:0]     sel_byte;

   assign widx  = req_addr[ADDR_W-1:2];
   assign lane  = req_addr[1:0];
   assign is_rd = req_vld && !req_wr;
   assign is_wr = req_vld &&  req_wr;

   bes_bank #(.WORDS(WORDS)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (widx),
      .rd_cw   (stored_cw),
      .wr_en   (is_wr),
      .wr_idx  (widx),
      .wr_cw   (new_cw),
      .inj_en  (inj_en),
      .inj_idx (inj_word),
      .inj_pos (inj_pos)
   );

   bes_decode dec_i (
      .cw_i   (stored_cw),
      .data_o (dec_data),
      .err_o  (dec_err)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*8 +: 8] = (lane == 2'(l)) ? req_wdata : dec_data[l*8 +: 8];
   end

   bes_encode enc_i (
      .data_i (merged),
      .cw_o   (new_cw)
   );

   always_comb begin
      sel_byte = '0;
      for (int l = 0; l < LANES; l++)
         if (lane == 2'(l)) sel_byte = dec_data[l*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld    <= 1'b0;
         rd_data   <= '0;
         corr_flag <= 1'b0;
      end else begin
         rd_vld <= is_rd;
         if (is_rd) begin
            rd_data   <= sel_byte;
            corr_flag <= req_first ? dec_err : (corr_flag | dec_err);
         end
      end
   end
endmodule

// File: rtl/byte_ecc_store_chk.sv
module byte_ecc_store_chk #(
   parameter int ADDR_W = 6
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic              req_wr,
   input logic              req_first,
   input logic [ADDR_W-1:0] req_addr,
   input logic              inj_en,
   input logic              rd_vld,
   input logic [7:0]        rd_data,
   input logic              corr_flag
);
   // R1
   rd_vld_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !req_wr) |=> rd_vld);
   // R1
   rd_vld_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_vld && !req_wr) |=> !rd_vld);
   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_vld && !req_wr) |=> $stable(corr_flag));
   // R5
   flag_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !req_wr && !req_first && corr_flag) |=> corr_flag);
   // R7
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!corr_flag && !rd_vld));
   // R2
   repeat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !req_wr && $past(req_vld) && !$past(req_wr) &&
       req_addr == $past(req_addr) && !$past(inj_en)) |=> $stable(rd_data));
endmodule

bind byte_ecc_store byte_ecc_store_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_vld   (req_vld),
   .req_wr    (req_wr),
   .req_first (req_first),
   .req_addr  (req_addr),
   .inj_en    (inj_en),
   .rd_vld    (rd_vld),
   .rd_data   (rd_data),
   .corr_flag (corr_flag)
);

// File: tb/byte_ecc_store_tb_top.sv
`timescale 1ns/1ps
module byte_ecc_store_tb_top;
   localparam int AW = 6;
   localparam int NB = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_vld = 1'b0, req_wr = 1'b0, req_first = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_wdata = '0;
   logic          inj_en = 1'b0;
   logic [AW-3:0] inj_word = '0;
   logic [5:0]    inj_pos = '0;
   logic          rd_vld;
   logic [7:0]    rd_data;
   logic          corr_flag;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [7:0] ref_mem [NB];

   always #2 clk = ~clk;

   byte_ecc_store #(.ADDR_W(AW)) dut_i (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_byte(input int a, input logic [7:0] d);
      @(negedge clk);
      req_vld = 1; req_wr = 1; req_first = 0; req_addr = AW'(a); req_wdata = d;
      @(negedge clk);
      req_vld = 0; req_wr = 0;
      ref_mem[a] = d;
   endtask

   task automatic rd_byte(input int a, input bit first, output logic [7:0] d, output logic f);
      @(negedge clk);
      req_vld = 1; req_wr = 0; req_first = first; req_addr = AW'(a);
      @(negedge clk);
      req_vld = 0; req_first = 0;
      d = rd_data; f = corr_flag;
   endtask

   task automatic inject(input int w, input int p);
      @(negedge clk);
      inj_en = 1; inj_word = (AW-2)'(w); inj_pos = 6'(p);
      @(negedge clk);
      inj_en = 0;
   endtask

   task automatic t_reset();
      logic [7:0] d; logic f;
      check(rd_vld == 0, "R7 rd_vld after reset", rd_vld, 0);
      check(corr_flag == 0, "R7 flag after reset", corr_flag, 0);
      rd_byte(21, 1, d, f);
      check(d == 0, "R7 zero data", d, 0);
      check(f == 0, "R7 zero word needs no repair", f, 0);
   endtask

   task automatic t_fill();
      logic [7:0] d; logic f;
      for (int a = 0; a < NB; a++) wr_byte(a, 8'((a * 37 + 11) ^ (a << 3)));
      for (int a = 0; a < NB; a += 5) begin
         rd_byte(a, 1, d, f);
         check(d == ref_mem[a], "R1 read back", d, ref_mem[a]);
         check(f == 0, "R4 clean read", f, 0);
      end
      wr_byte(41, 8'h5A);
      for (int a = 40; a < 44; a++) begin
         rd_byte(a, 1, d, f);
         check(d == ref_mem[a], "R3 only target lane changed", d, ref_mem[a]);
      end
   endtask

   task automatic t_sweep();
      logic [7:0] d; logic f;
      for (int p = 0; p < 38; p++) begin
         inject(3, p);
         rd_byte(12 + (p % 4), 1, d, f);
         check(d == ref_mem[12 + (p % 4)], (p == 0 || p == 1 || p == 3 || p == 7 || p == 15 || p == 31) ? "R6 check-bit flip data" : "R2 single flip repaired", d, ref_mem[12 + (p % 4)]);
         check(f == 1, "R4 flag on repaired read", f, 1);
         rd_byte(12 + ((p + 1) % 4), 0, d, f);
         check(d == ref_mem[12 + ((p + 1) % 4)], "R2 other lane repaired", d, ref_mem[12 + ((p + 1) % 4)]);
         wr_byte(12, ref_mem[12]);
         rd_byte(13, 1, d, f);
         check(d == ref_mem[13] && f == 0, "R3 rewrite scrubs word", {d, 7'b0, f}, {ref_mem[13], 8'h00});
      end
   endtask

   task automatic t_rmw();
      logic [7:0] d; logic f;
      inject(7, 20);
      wr_byte(28, 8'hC3);
      rd_byte(30, 1, d, f);
      check(d == ref_mem[30], "R3 neighbour repaired by write", d, ref_mem[30]);
      check(f == 0, "R3 check bits regenerated", f, 0);
   endtask

   task automatic t_multi();
      logic [7:0] d; logic f;
      inject(5, 9);
      rd_byte(16, 1, d, f);
      check(f == 0, "R4 clean first beat", f, 0);
      rd_byte(21, 0, d, f);
      check(f == 1, "R5 beat with repair sets flag", f, 1);
      rd_byte(25, 0, d, f);
      check(f == 1, "R5 clean beat keeps flag", f, 1);
      wr_byte(2, 8'h77);
      check(corr_flag == 1, "R8 write keeps flag", corr_flag, 1);
      repeat (3) @(negedge clk);
      check(corr_flag == 1, "R8 idle keeps flag", corr_flag, 1);
      rd_byte(25, 1, d, f);
      check(f == 0, "R4 new clean operation clears flag", f, 0);
      wr_byte(20, ref_mem[20]);
   endtask

   task automatic t_inject_ignored();
      logic [7:0] d; logic f;
      inject(1, 40);
      rd_byte(5, 1, d, f);
      check(d == ref_mem[5] && f == 0, "R9 out-of-range index ignored", {d, 7'b0, f}, {ref_mem[5], 8'h00});
      @(negedge clk);
      req_vld = 1; req_wr = 1; req_first = 0; req_addr = AW'(9); req_wdata = 8'hE1;
      inj_en = 1; inj_word = (AW-2)'(2); inj_pos = 6'd12;
      @(negedge clk);
      req_vld = 0; req_wr = 0; inj_en = 0;
      ref_mem[9] = 8'hE1;
      rd_byte(10, 1, d, f);
      check(d == ref_mem[10] && f == 0, "R9 write wins over flip", {d, 7'b0, f}, {ref_mem[10], 8'h00});
      rd_byte(9, 1, d, f);
      check(d == 8'hE1, "R9 written byte stored", d, 8'hE1);
   endtask

   initial begin
      for (int a = 0; a < NB; a++) ref_mem[a] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill();
      t_sweep();
      t_rmw();
      t_multi();
      t_inject_ignored();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule